// File: doc/BRIEF.md
# I2C Bus Recovery Clock Sequencer

This block frees an I2C bus that a target is holding down, typically because a transfer was cut off halfway and the target still believes it owns SDA. After a one-cycle start request it takes charge of the open-drain lines while the regular byte controller is disabled. It produces recovery clocks on SCL at the normal 100 kHz rate, each level lasting one half period (5 µs at the default clock setting). It stops as soon as the target lets go of SDA. When the sequence ends it reports one of three outcomes: the bus is free, SCL is held low by something else, or SDA is still low.

The default mode is bitwise. Only SCL is driven, and SDA is watched at the end of every high phase. A second mode can be chosen at start time for systems without direct line access. It sends a START, nine clocks with SDA released (an all-ones byte followed by a not-acknowledge), and then a STOP. This mode is a weaker recovery: an EEPROM caught in its acknowledge slot may come out of it still holding SDA. It should only be used when the bitwise mode is not available.

The line inputs must already be synchronised to `clk`. The `*_oe_o` outputs pull their line low when high. The block has no data stream, so every pin is a plain level or one-cycle pulse with no valid/ready handshake.

Top module: `i2c_unstick_seq`

## Requirements
- R1: After reset both line drivers are off, `busy_o` is low and `done_o` is low.
- R2: Every SCL low phase driven in bitwise mode lasts exactly HALF_CYC = CLK_HZ/(2*BUS_HZ) clock cycles. Before the first low phase, SCL is left released for one half period.
- R3: At every high-phase sample point before the ninth clock, SCL is checked first. If it reads low, the run ends at once with status 1 (SCL stuck) and no further clocks.
- R4: If SDA reads high at a high-phase sample point, the run ends with status 0 (bus free) without another SCL low phase. If SDA is already high at the first sample, zero clocks are sent.
- R5: At most 9 SCL low pulses are sent in bitwise mode. If SDA is still low at the sample after the ninth clock, the status is 2 (SDA stuck).
- R6: In bitwise mode (`byte_mode_i` = 0 at the accepted start) SDA is never driven.
- R7: Completion is a single-cycle `done_o` pulse. `status_o` is valid in that cycle with the encoding 0 = free, 1 = SCL stuck, 2 = SDA stuck; the value 3 never appears. `busy_o` is high from the cycle after an accepted start until the cycle of `done_o`.
- R8: A start request while `busy_o` is high is ignored. The run in progress is neither restarted nor lengthened, and no second completion follows.
- R9: In byte mode (`byte_mode_i` = 1 at the accepted start) the block produces a START, nine released-SDA clocks, and a STOP. This gives exactly 10 SCL low pulses and exactly 2 SDA low drives.
- R10: In byte mode, if SDA is low after the STOP, the status is 2; otherwise it is 0. SCL is checked at each high phase, and a low reading gives status 1.
- R11: In the cycle of `done_o`, both line drivers are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Single-cycle request to begin recovery |
| byte_mode_i | input | 1 | Selects byte mode when sampled with an accepted start |
| scl_i | input | 1 | Synchronised SCL line level |
| sda_i | input | 1 | Synchronised SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when high |
| sda_oe_o | output | 1 | Pull SDA low when high |
| busy_o | output | 1 | A recovery run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | Outcome code, valid with done_o |

## Verification
The assertions rely on `scl_i` and `sda_i` being clean, already-synchronised levels, and on `start_i` being a pulse that may arrive at any time, including mid-run. The stimulus models the bus as a wired-AND of the block's drivers and a simulated target. That target releases SDA after a chosen number of SCL rising edges and can optionally clamp SCL low after a chosen number of falls, so the line inputs only ever show values a real open-drain bus could present. Start requests are issued from idle, with a deliberate extra request placed inside a busy window.

// File: rtl/unstick_pkg.sv
package unstick_pkg;
  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_SCL_LOW = 2'd1,
    ST_SDA_LOW = 2'd2
  } rec_status_t;
endpackage

// File: rtl/unstick_half_timer.sv
module unstick_half_timer #(
  parameter int HALF_CYC = 625
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = $clog2(HALF_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick_o = run_i && (cnt == LAST);

  // R2: the count never leaves its window
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/unstick_bitwise.sv
module unstick_bitwise
  import unstick_pkg::*;
#(
  parameter int MAX_CLOCKS = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go_i,
  input  logic        tick_i,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        busy_o,
  output logic        scl_oe_o,
  output logic        fin_o,
  output rec_status_t code_o
);
  localparam int NW = $clog2(MAX_CLOCKS + 1);
  localparam logic [NW-1:0] NMAX = NW'(MAX_CLOCKS);

  typedef enum logic [1:0] {B_IDLE, B_PREP, B_HIGH, B_LOW} bstate_t;

  bstate_t       st;
  logic [NW-1:0] nclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= B_IDLE;
      nclk   <= '0;
      fin_o  <= 1'b0;
      code_o <= ST_OK;
    end else begin
      fin_o <= 1'b0;
      case (st)
        B_IDLE: begin
          if (go_i) begin
            st   <= B_PREP;
            nclk <= '0;
          end
        end
        B_PREP, B_HIGH: begin
          if (tick_i) begin
            if (nclk < NMAX && !scl_i) begin
              st <= B_IDLE; fin_o <= 1'b1; code_o <= ST_SCL_LOW;
            end else if (sda_i) begin
              st <= B_IDLE; fin_o <= 1'b1; code_o <= ST_OK;
            end else if (nclk == NMAX) begin
              st <= B_IDLE; fin_o <= 1'b1; code_o <= ST_SDA_LOW;
            end else begin
              st <= B_LOW;
            end
          end
        end
        B_LOW: begin
          if (tick_i) begin
            st   <= B_HIGH;
            nclk <= nclk + 1'b1;
          end
        end
        default: st <= B_IDLE;
      endcase
    end
  end

  assign busy_o   = (st != B_IDLE);
  assign scl_oe_o = (st == B_LOW);

  // R5: never more clocks than the cap
  a_r5_clock_cap: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> nclk <= NMAX);
  // R3: an SCL fault report follows a low SCL reading
  a_r3_scl_seen_low: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_o && code_o == ST_SCL_LOW) |-> !$past(scl_i));
  // R4: a free report follows a high SDA reading
  a_r4_sda_seen_high: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_o && code_o == ST_OK) |-> $past(sda_i));
endmodule

// File: rtl/unstick_bytewise.sv
module unstick_bytewise
  import unstick_pkg::*;
#(
  parameter int NBITS = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go_i,
  input  logic        tick_i,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        busy_o,
  output logic        scl_oe_o,
  output logic        sda_oe_o,
  output logic        fin_o,
  output rec_status_t code_o
);
  localparam int BW = $clog2(NBITS + 1);
  localparam logic [BW-1:0] BLAST = BW'(NBITS - 1);

  typedef enum logic [3:0] {
    Y_IDLE, Y_LEAD, Y_STA, Y_ALO, Y_BLO, Y_BHI, Y_QLO, Y_PLO, Y_PHI, Y_PEND
  } ystate_t;

  ystate_t       st;
  logic [BW-1:0] nbit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= Y_IDLE;
      nbit   <= '0;
      fin_o  <= 1'b0;
      code_o <= ST_OK;
    end else begin
      fin_o <= 1'b0;
      if (st == Y_IDLE) begin
        if (go_i) st <= Y_LEAD;
      end else if (tick_i) begin
        case (st)
          Y_LEAD: st <= Y_STA;
          Y_STA:  st <= Y_ALO;
          Y_ALO: begin
            st   <= Y_BLO;
            nbit <= '0;
          end
          Y_BLO:  st <= Y_BHI;
          Y_BHI: begin
            if (!scl_i) begin
              st <= Y_IDLE; fin_o <= 1'b1; code_o <= ST_SCL_LOW;
            end else if (nbit == BLAST) begin
              st <= Y_QLO;
            end else begin
              st   <= Y_BLO;
              nbit <= nbit + 1'b1;
            end
          end
          Y_QLO:  st <= Y_PLO;
          Y_PLO:  st <= Y_PHI;
          Y_PHI: begin
            if (!scl_i) begin
              st <= Y_IDLE; fin_o <= 1'b1; code_o <= ST_SCL_LOW;
            end else begin
              st <= Y_PEND;
            end
          end
          Y_PEND: begin
            st     <= Y_IDLE;
            fin_o  <= 1'b1;
            code_o <= sda_i ? ST_OK : ST_SDA_LOW;
          end
          default: st <= Y_IDLE;
        endcase
      end
    end
  end

  assign busy_o   = (st != Y_IDLE);
  assign scl_oe_o = (st == Y_ALO) || (st == Y_BLO) || (st == Y_QLO) || (st == Y_PLO);
  assign sda_oe_o = (st == Y_STA) || (st == Y_ALO) || (st == Y_PLO) || (st == Y_PHI);

  // R9: bit counter stays inside the byte
  a_r9_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> nbit <= BLAST);
  // R10: SDA fault comes only from the final check
  a_r10_sda_final: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_o && code_o == ST_SDA_LOW) |-> !$past(sda_i));
endmodule

// File: rtl/i2c_unstick_seq.sv
module i2c_unstick_seq
  import unstick_pkg::*;
#(
  parameter int CLK_HZ        = 125_000_000,
  parameter int BUS_HZ        = 100_000,
  parameter int MAX_CLOCKS    = 9,
  parameter bit HAS_BYTE_MODE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       byte_mode_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] status_o
);
  localparam int HALF_CYC = CLK_HZ / (2 * BUS_HZ);

  logic        tick;
  logic        go_bit, go_byte;
  logic        bit_busy, bit_scl, bit_fin;
  logic        byt_busy, byt_scl, byt_sda, byt_fin;
  rec_status_t bit_code, byt_code;

  assign busy_o  = bit_busy || byt_busy;
  assign go_byte = start_i && !busy_o && HAS_BYTE_MODE && byte_mode_i;
  assign go_bit  = start_i && !busy_o && !(HAS_BYTE_MODE && byte_mode_i);

  unstick_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(busy_o), .tick_o(tick)
  );

  unstick_bitwise #(.MAX_CLOCKS(MAX_CLOCKS)) u_bit (
    .clk(clk), .rst_n(rst_n), .go_i(go_bit), .tick_i(tick),
    .scl_i(scl_i), .sda_i(sda_i), .busy_o(bit_busy), .scl_oe_o(bit_scl),
    .fin_o(bit_fin), .code_o(bit_code)
  );

  generate
    if (HAS_BYTE_MODE) begin : g_byte
      unstick_bytewise #(.NBITS(9)) u_byte (
        .clk(clk), .rst_n(rst_n), .go_i(go_byte), .tick_i(tick),
        .scl_i(scl_i), .sda_i(sda_i), .busy_o(byt_busy), .scl_oe_o(byt_scl),
        .sda_oe_o(byt_sda), .fin_o(byt_fin), .code_o(byt_code)
      );
    end else begin : g_nobyte
      assign byt_busy = 1'b0;
      assign byt_scl  = 1'b0;
      assign byt_sda  = 1'b0;
      assign byt_fin  = 1'b0;
      assign byt_code = ST_OK;
    end
  endgenerate

  assign scl_oe_o = bit_scl || byt_scl;
  assign sda_oe_o = byt_sda;
  assign done_o   = bit_fin || byt_fin;
  assign status_o = bit_fin ? bit_code : byt_code;

  // R6: bitwise runs leave SDA alone
  a_r6_sda_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    bit_busy |-> !sda_oe_o);
  // R7: completion is a single pulse with a legal code
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r7_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> status_o != 2'd3);
  // R8: a request during a run does not launch a second engine
  a_r8_one_engine: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_busy && byt_busy));
  // R11: lines released when finished
  a_r11_released: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!scl_oe_o && !sda_oe_o));
endmodule

// File: tb/sim_i2c_unstick_seq.sv
module sim_i2c_unstick_seq;
  localparam int CLK_HZ = 2_000_000;
  localparam int BUS_HZ = 100_000;
  localparam int HALF   = CLK_HZ / (2 * BUS_HZ);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, bmode = 1'b0;
  logic scl_oe, sda_oe, busy, done;
  logic [1:0] status;

  int total = 0, bad = 0;
  int rel_after = 0, stuck_en = 0, stuck_k = 0;
  int falls = 0, sdadrv = 0, rises = 0, dones = 0, lowrun = 0, badlow = 0;
  int last_status = 0;
  logic p_scl_oe = 0, p_sda_oe = 0, p_scl_line = 1;

  wire scl_line = !scl_oe && !(stuck_en != 0 && falls >= stuck_k);
  wire sda_line = !sda_oe && !(rises < rel_after);

  always #4 clk = ~clk;

  i2c_unstick_seq #(.CLK_HZ(CLK_HZ), .BUS_HZ(BUS_HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .byte_mode_i(bmode),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .busy_o(busy), .done_o(done), .status_o(status)
  );

  always @(negedge clk) begin
    if (scl_oe && !p_scl_oe) falls++;
    if (sda_oe && !p_sda_oe) sdadrv++;
    if (scl_line && !p_scl_line) rises++;
    if (scl_oe) lowrun++;
    else if (p_scl_oe) begin
      if (!bmode && lowrun != HALF) badlow++;
      lowrun = 0;
    end
    if (done) begin dones++; last_status = int'(status); end
    p_scl_oe = scl_oe; p_sda_oe = sda_oe; p_scl_line = scl_line;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_status(int m, int r, int se, int k);
    int n;
    if (m != 0) return (r > 10) ? 2 : 0;
    n = (r < 9) ? r : 9;
    if (se != 0 && k < 9 && k <= n) return 1;
    return (r <= 9) ? 0 : 2;
  endfunction

  function automatic int exp_falls(int m, int r, int se, int k);
    int n;
    if (m != 0) return 10;
    n = (r < 9) ? r : 9;
    if (se != 0 && k < 9 && k <= n) return k;
    return n;
  endfunction

  task automatic run(input int m, input int r, input int se, input int k, input bit again);
    int wd;
    @(negedge clk);
    rel_after = r; stuck_en = se; stuck_k = k; bmode = m[0];
    falls = 0; sdadrv = 0; rises = 0; dones = 0; badlow = 0; lowrun = 0;
    p_scl_line = scl_line;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7 busy after start", int'(busy), 1);
    if (again) begin
      repeat (4) @(negedge clk);
      if (busy) begin
        start = 1'b1; @(negedge clk); start = 1'b0;
      end
    end
    wd = 0;
    while (dones == 0 && wd < 4000) begin @(negedge clk); wd++; end
    chk(wd < 4000, "R7 watchdog", wd, 4000);
    chk(busy == 1'b0, "R7 busy drops at done", int'(busy), 0);
    chk(last_status == exp_status(m, r, se, k), "R3 R4 R5 R10 status",
        last_status, exp_status(m, r, se, k));
    chk(falls == exp_falls(m, r, se, k), "R5 R9 scl pulses", falls, exp_falls(m, r, se, k));
    chk(sdadrv == ((m != 0) ? 2 : 0), "R6 R9 sda drives", sdadrv, (m != 0) ? 2 : 0);
    chk(badlow == 0, "R2 low phase length", badlow, 0);
    chk(!scl_oe && !sda_oe, "R11 lines released", int'(scl_oe) + int'(sda_oe), 0);
    repeat (3 * HALF) @(negedge clk);
    chk(dones == 1 && !busy, "R8 single completion", dones, 1);
    stuck_en = 0; rel_after = 0;
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy && !done, "R1 reset state",
        int'(scl_oe) + int'(sda_oe) + int'(busy) + int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy && !done, "R1 idle after reset",
        int'(scl_oe) + int'(sda_oe) + int'(busy) + int'(done), 0);
    // directed corners
    run(0, 0, 0, 0, 1'b1);   // R4 released at once, extra start R8
    run(0, 3, 0, 0, 1'b0);   // R4 early stop
    run(0, 9, 0, 0, 1'b0);   // R5 release on ninth clock
    run(0, 10, 0, 0, 1'b1);  // R5 SDA stuck, R8
    run(0, 12, 1, 0, 1'b0);  // R3 SCL stuck from the start
    run(0, 12, 1, 4, 1'b0);  // R3 SCL clamps after 4 pulses
    run(0, 12, 1, 9, 1'b0);  // R5 clamp after ninth does not matter
    run(1, 0, 0, 0, 1'b1);   // R9 byte mode clean
    run(1, 10, 0, 0, 0);     // R10 released by last edge
    run(1, 11, 0, 0, 0);     // R10 still low
    // constrained random
    for (int i = 0; i < 24; i++) begin
      int m, r, se, k;
      m  = ($urandom % 5 == 0) ? 1 : 0;
      r  = $urandom % 13;
      se = (m == 0 && $urandom % 4 == 0) ? 1 : 0;
      k  = $urandom % 11;
      run(m, r, se, k, $urandom % 3 == 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190_000) @(posedge clk);
    total++; bad++;
    $display("FAIL R7 global watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule